// File: doc/BRIEF.md
# Register Rename Map with Free List

This block sits in the front end of an out-of-order core and turns architectural register names into physical register names, one instruction per cycle. Register names in the instruction set are few and get reused, so a later write to the same name looks as though it must wait for earlier uses. Each write receives a fresh physical register instead. This removes those false dependencies, and only true producer-to-consumer ordering remains.

Each incoming instruction carries two source names and, optionally, one destination name. The sources are looked up in a map table that holds exactly one physical register for every architectural register. A destination takes the oldest entry of a first-in first-out free list, and the map entry for that name is overwritten. The physical register that the new mapping replaces is handed out with the result. A later stage that knows when that register is dead returns it on the release stream, and it joins the tail of the free list.

The rename input and the result output are valid/ready streams. An instruction is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while the output register holds an unconsumed result, and it is also low when the presented instruction has a destination and the free list is empty. While `out_valid` is high and `out_ready` is low, the output payload does not change. The release stream is taken whenever `rel_valid` and `rel_ready` are both high. `alloc_stall` is a plain status pin that is high whenever no physical register is free.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers NUM_ARCH up to NUM_PHYS-1 in ascending order, with NUM_ARCH at the head. `out_valid` is 0, `alloc_stall` is 0 and `in_ready` is 1.
- R2: `out_psrc0` and `out_psrc1` are the map entries of `in_src0` and `in_src1` as they stood before the same instruction's destination update. A source equal to the destination therefore yields the old physical name.
- R3: An accepted instruction with `in_has_dst`=1 receives the head of the free list as `out_pdst` and the replaced mapping as `out_pold`. Every later source read of that architectural register returns `out_pdst` until the register is written again.
- R4: An accepted instruction with `in_has_dst`=0 takes no free-list entry and leaves the map unchanged, so the next destination receives the same head register. It is reported with `out_has_dst`=0.
- R5: Registers released on the release stream join the free-list tail and are allocated in order of release, after all entries already in the list.
- R6: While the free list is empty, `alloc_stall` is 1 and an instruction with a destination is not accepted (`in_ready`=0). An instruction without a destination is still accepted.
- R7: While `out_valid`=1 and `out_ready`=0, the output payload stays stable and `in_ready` is 0.
- R8: With `out_ready` held high, an instruction is accepted on every cycle, and each result appears on the output one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Rename request valid |
| in_ready | output | 1 | Rename request accepted this cycle when high together with in_valid |
| in_src0 | input | AW | First source architectural register |
| in_src1 | input | AW | Second source architectural register |
| in_has_dst | input | 1 | Instruction writes a destination |
| in_dst | input | AW | Destination architectural register |
| out_valid | output | 1 | Renamed result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_psrc0 | output | PW | Physical name of first source |
| out_psrc1 | output | PW | Physical name of second source |
| out_has_dst | output | 1 | Result carries a destination |
| out_pdst | output | PW | Newly allocated physical register |
| out_pold | output | PW | Physical register the new mapping replaced |
| rel_valid | input | 1 | Release request valid |
| rel_ready | output | 1 | Free list can take a release |
| rel_pidx | input | PW | Physical register being returned |
| alloc_stall | output | 1 | High while no physical register is free |

## Verification
A corrupted map entry shows up as a wrong `out_psrc0`/`out_psrc1` on the first later instruction that reads that architectural register. It also shows up as a wrong `out_pold` on the next write to it, which appears one clock after that instruction is accepted. A slip in the free-list pointers shows up as an out-of-order or repeated `out_pdst` on the next allocation. A count error shows up as `alloc_stall` and `in_ready` changing too early or too late, at the cycle the list should drain or refill. The bench takes the list from full to empty, refills it through releases in a known order, and forces back-pressure, so each of these faults reaches the ports within a few cycles of its cause.

// File: rtl/rn_pkg.sv
package rn_pkg;

  localparam int unsigned RN_ARCH_DEFAULT = 8;
  localparam int unsigned RN_PHYS_DEFAULT = 16;

  // bits needed to hold a count from 0 up to n
  function automatic int unsigned rn_count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int unsigned NUM_ARCH = rn_pkg::RN_ARCH_DEFAULT,
  parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_DEFAULT,
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = rn_pkg::rn_count_bits(NUM_PHYS),
  localparam int unsigned NUM_FREE = NUM_PHYS - NUM_ARCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_idx,
  output logic [PW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [PW-1:0] slots [NUM_PHYS];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_pop, do_push;

  assign do_pop  = pop && !empty;
  assign do_push = push && !full;
  assign head    = slots[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(NUM_PHYS));

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        if (i < NUM_FREE) slots[i] <= PW'(NUM_ARCH + i);
        else              slots[i] <= '0;
      end
    end else if (do_push) begin
      slots[wr_ptr] <= push_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= PW'(NUM_FREE % NUM_PHYS);
      count  <= CW'(NUM_FREE);
    end else begin
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned NUM_ARCH = rn_pkg::RN_ARCH_DEFAULT,
  parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_DEFAULT,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a0,
  input  logic [AW-1:0] rd_a1,
  input  logic [AW-1:0] rd_a2,
  output logic [PW-1:0] rd_p0,
  output logic [PW-1:0] rd_p1,
  output logic [PW-1:0] rd_p2,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_a,
  input  logic [PW-1:0] wr_p
);

  logic [PW-1:0] entry [NUM_ARCH];

  for (genvar e = 0; e < NUM_ARCH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             entry[e] <= PW'(e);
      else if (wr_en && wr_a == AW'(e))       entry[e] <= wr_p;
    end
  end

  // reads see the table before this cycle's write lands
  assign rd_p0 = entry[rd_a0];
  assign rd_p1 = entry[rd_a1];
  assign rd_p2 = entry[rd_a2];

endmodule

// File: rtl/rn_out_reg.sv
module rn_out_reg #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] d_psrc0,
  input  logic [PW-1:0] d_psrc1,
  input  logic          d_has_dst,
  input  logic [PW-1:0] d_pdst,
  input  logic [PW-1:0] d_pold,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [PW-1:0] out_psrc0,
  output logic [PW-1:0] out_psrc1,
  output logic          out_has_dst,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_psrc0   <= '0;
      out_psrc1   <= '0;
      out_has_dst <= 1'b0;
      out_pdst    <= '0;
      out_pold    <= '0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_psrc0   <= d_psrc0;
      out_psrc1   <= d_psrc1;
      out_has_dst <= d_has_dst;
      out_pdst    <= d_pdst;
      out_pold    <= d_pold;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
  parameter int unsigned NUM_ARCH = rn_pkg::RN_ARCH_DEFAULT,
  parameter int unsigned NUM_PHYS = rn_pkg::RN_PHYS_DEFAULT,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS),
  localparam int unsigned CW = rn_pkg::rn_count_bits(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  input  logic          in_has_dst,
  input  logic [AW-1:0] in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_psrc0,
  output logic [PW-1:0] out_psrc1,
  output logic          out_has_dst,
  output logic [PW-1:0] out_pdst,
  output logic [PW-1:0] out_pold,
  input  logic          rel_valid,
  output logic          rel_ready,
  input  logic [PW-1:0] rel_pidx,
  output logic          alloc_stall
);

  logic          slot_free, fire, alloc;
  logic          fl_empty, fl_full;
  logic [PW-1:0] fl_head;
  logic [CW-1:0] fl_count;
  logic [PW-1:0] map_s0, map_s1, map_old;

  assign slot_free   = !out_valid || out_ready;
  assign in_ready    = slot_free && (!in_has_dst || !fl_empty);
  assign fire        = in_valid && in_ready;
  assign alloc       = fire && in_has_dst;
  assign rel_ready   = !fl_full;
  assign alloc_stall = fl_empty;

  rn_free_fifo #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .push     (rel_valid),
    .push_idx (rel_pidx),
    .head     (fl_head),
    .empty    (fl_empty),
    .full     (fl_full),
    .count    (fl_count)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_a0 (in_src0),
    .rd_a1 (in_src1),
    .rd_a2 (in_dst),
    .rd_p0 (map_s0),
    .rd_p1 (map_s1),
    .rd_p2 (map_old),
    .wr_en (alloc),
    .wr_a  (in_dst),
    .wr_p  (fl_head)
  );

  rn_out_reg #(.PW(PW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fire),
    .d_psrc0     (map_s0),
    .d_psrc1     (map_s1),
    .d_has_dst   (in_has_dst),
    .d_pdst      (in_has_dst ? fl_head : '0),
    .d_pold      (in_has_dst ? map_old : '0),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_psrc0   (out_psrc0),
    .out_psrc1   (out_psrc1),
    .out_has_dst (out_has_dst),
    .out_pdst    (out_pdst),
    .out_pold    (out_pold)
  );

endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int unsigned PW = 4,
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_has_dst,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_psrc0,
  input logic [PW-1:0] out_psrc1,
  input logic          out_has_dst,
  input logic [PW-1:0] out_pdst,
  input logic [PW-1:0] out_pold,
  input logic          rel_valid,
  input logic          rel_ready,
  input logic          alloc_stall,
  input logic [CW-1:0] fl_count
);

  // R3
  fresh_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_has_dst) |-> (out_pdst != out_pold));

  // R4
  nodst_keeps_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_has_dst && !(rel_valid && rel_ready))
      |=> (fl_count == $past(fl_count)));

  // R3
  alloc_takes_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_has_dst && !(rel_valid && rel_ready))
      |=> (fl_count == $past(fl_count) - 1'b1));

  // R6
  empty_blocks_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_stall && in_has_dst) |-> !in_ready);

  // R7
  hold_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_psrc0) && $stable(out_psrc1)
      && $stable(out_has_dst) && $stable(out_pdst) && $stable(out_pold)));

  // R7
  held_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind rn_rename_top rn_rename_chk #(.PW(PW), .CW(CW)) u_chk (.*);

// File: tb/tb_rn_rename_top.sv
module tb_rn_rename_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_has_dst;
  logic [2:0] in_src0, in_src1, in_dst;
  logic       out_valid, out_ready, out_has_dst;
  logic [3:0] out_psrc0, out_psrc1, out_pdst, out_pold;
  logic       rel_valid, rel_ready;
  logic [3:0] rel_pidx;
  logic       alloc_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rn_rename_top dut (.*);

  // fields: src0 src1 has_dst dst | exp psrc0 psrc1 pdst pold
  localparam logic [25:0] VEC [8] = '{
    {3'd3, 3'd4, 1'b1, 3'd2, 4'd3,  4'd4,  4'd8,  4'd2},
    {3'd2, 3'd1, 1'b0, 3'd0, 4'd8,  4'd1,  4'd0,  4'd0},
    {3'd1, 3'd0, 1'b1, 3'd1, 4'd1,  4'd0,  4'd9,  4'd1},
    {3'd5, 3'd6, 1'b1, 3'd2, 4'd5,  4'd6,  4'd10, 4'd8},
    {3'd2, 3'd1, 1'b0, 3'd0, 4'd10, 4'd9,  4'd0,  4'd0},
    {3'd1, 3'd1, 1'b1, 3'd1, 4'd9,  4'd9,  4'd11, 4'd9},
    {3'd7, 3'd0, 1'b1, 3'd0, 4'd7,  4'd0,  4'd12, 4'd0},
    {3'd0, 3'd2, 1'b0, 3'd0, 4'd12, 4'd10, 4'd0,  4'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] s0, input logic [2:0] s1,
                       input logic hd, input logic [2:0] d);
    @(negedge clk);
    in_src0 = s0; in_src1 = s1; in_has_dst = hd; in_dst = d; in_valid = 1'b1;
    #1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_out(input string req, input int e0, input int e1,
                           input logic hd, input int epd, input int epo);
    chk({req, " out_valid"}, out_valid, 1);
    chk({req, " psrc0"}, out_psrc0, e0);
    chk({req, " psrc1"}, out_psrc1, e1);
    chk({req, " has_dst"}, out_has_dst, hd);
    if (hd) begin
      chk({req, " pdst"}, out_pdst, epd);
      chk({req, " pold"}, out_pold, epo);
    end
  endtask

  task automatic release_reg(input logic [3:0] p);
    @(negedge clk);
    rel_valid = 1'b1; rel_pidx = p;
    @(posedge clk);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_src0 = '0; in_src1 = '0; in_has_dst = 1'b0;
    in_dst = '0; out_ready = 1'b1; rel_valid = 1'b0; rel_pidx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 out_valid", out_valid, 0);
    chk("R1 alloc_stall", alloc_stall, 0);
    chk("R1 in_ready", in_ready, 1);

    // table: R2 sources, R3 destinations, R4 no-destination rows
    for (int k = 0; k < 8; k++) begin
      logic [25:0] v;
      v = VEC[k];
      issue(v[25:23], v[22:20], v[19], v[18:16]);
      check_out(v[19] ? "R2/R3 vec" : "R2/R4 vec", v[15:12], v[11:8], v[19], v[7:4], v[3:0]);
    end

    // drain free list 13,14,15 (R3)
    issue(3'd2, 3'd2, 1'b1, 3'd3); check_out("R3 drain", 10, 10, 1'b1, 13, 3);
    issue(3'd0, 3'd0, 1'b1, 3'd4); check_out("R3 drain", 12, 12, 1'b1, 14, 4);
    issue(3'd1, 3'd1, 1'b1, 3'd5); check_out("R3 drain", 11, 11, 1'b1, 15, 5);
    chk("R6 alloc_stall empty", alloc_stall, 1);

    // R6: destination blocked, non-destination passes
    @(negedge clk);
    in_src0 = 3'd6; in_src1 = 3'd6; in_has_dst = 1'b1; in_dst = 3'd6; in_valid = 1'b1;
    #1;
    chk("R6 in_ready dst", in_ready, 0);
    @(negedge clk);
    chk("R6 in_ready dst held", in_ready, 0);
    chk("R6 nothing accepted", out_valid, 0);
    in_valid = 1'b0;
    issue(3'd3, 3'd4, 1'b0, 3'd0); check_out("R6 nodst accepted", 13, 14, 1'b0, 0, 0);

    // R5: releases in order 2 then 8
    release_reg(4'd2);
    release_reg(4'd8);
    chk("R5 alloc_stall refilled", alloc_stall, 0);
    issue(3'd0, 3'd0, 1'b1, 3'd6); check_out("R5 first release", 12, 12, 1'b1, 2, 6);
    issue(3'd0, 3'd0, 1'b1, 3'd7); check_out("R5 second release", 12, 12, 1'b1, 8, 7);
    chk("R6 alloc_stall again", alloc_stall, 1);

    // R7 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    issue(3'd6, 3'd7, 1'b0, 3'd0);
    check_out("R7 held", 2, 8, 1'b0, 0, 0);
    in_src0 = 3'd0; in_src1 = 3'd1; in_has_dst = 1'b0; in_valid = 1'b1;
    #1;
    chk("R7 in_ready held", in_ready, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R7 stable psrc0", out_psrc0, 2);
    chk("R7 stable psrc1", out_psrc1, 8);
    out_ready = 1'b1;
    #1;
    chk("R7 in_ready released", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    check_out("R7 after release", 12, 11, 1'b0, 0, 0);

    // R8 back-to-back acceptance
    in_src0 = 3'd2; in_src1 = 3'd3;
    @(posedge clk);
    @(negedge clk);
    check_out("R8 first", 10, 13, 1'b0, 0, 0);
    in_src0 = 3'd4; in_src1 = 3'd5;
    #1;
    chk("R8 in_ready each cycle", in_ready, 1);
    @(posedge clk);
    @(negedge clk);
    check_out("R8 second", 14, 15, 1'b0, 0, 0);
    in_valid = 1'b0;

    // R1 mid-run reset restores identity map and full list
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset alloc_stall", alloc_stall, 0);
    issue(3'd2, 3'd7, 1'b1, 3'd2); check_out("R1 after reset", 2, 7, 1'b1, 8, 2);

    done = 1'b1;
    finish_run();
  end

endmodule